// File: doc/BRIEF.md
# Engine-Priority Descriptor Memory Controller

This block lets two requesters share one single-port synchronous RAM that holds per-channel transfer descriptors. To each of them the RAM looks like a port of its own. The first requester is the DMA engine. It names a channel and a word index within that channel's descriptor, and it reads or writes a whole 64-bit word in one RAM cycle. The second requester is a 32-bit slave register bus. It reads and writes the same storage in 32-bit halves.

The engine has fixed priority. When both sides request in the same cycle, the engine's access goes to the RAM and the slave is stalled: its ready stays low until its own access has been serviced, and it must keep its request and its data steady during that time. A slave write covers only half of a RAM word. It is therefore a read followed by a merged write, over two RAM cycles, and no engine access can come between those two cycles.

Top module: `desc_mem_ctrl`

## Requirements
- R1: The storage holds CHAN_NUM × WORDS_PER_DESC words of 64 bits. An engine access goes to RAM word chan × WORDS_PER_DESC + word. Data the engine writes is returned by a later engine read of the same channel and word.
- R2: When the engine and an idle slave request in the same cycle, the engine is granted in that cycle. The slave's ready stays low in that cycle and in the next one, so the slave completes one cycle later than it would without the engine.
- R3: An engine request is granted in the cycle it is presented, except in the merge cycle of a slave write. An engine read returns its data with eng_rvalid_o high in the cycle after the grant. An engine write raises no eng_rvalid_o.
- R4: slv_addr_i addresses 32-bit units. Bit 0 selects the upper half (1) or the lower half (0) of a RAM word. The bits above bit 0 give the RAM word, chan × WORDS_PER_DESC + word.
- R5: A slave read that is not contended raises slv_ready_o and slv_rvalid_o together for one cycle, in the cycle after the RAM read, with the addressed half on slv_rdata_o.
- R6: A slave write changes only the addressed half of the RAM word and keeps the other half. It raises slv_ready_o in its second RAM cycle and never raises slv_rvalid_o.
- R7: No engine grant is given in the merge cycle of a slave write. An engine request that waits through that cycle is granted in the next cycle.
- R8: slv_ready_o is high for exactly one cycle per slave access. A stalled slave keeps its request, its direction, its address and its write data stable until ready.
- R9: While reset is held and after its release, eng_rvalid_o, slv_ready_o and slv_rvalid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eng_req_i | input | 1 | Engine access request, held until granted |
| eng_we_i | input | 1 | Engine write (1) or read (0) |
| eng_chan_i | input | $clog2(CHAN_NUM) | Channel number of the engine access |
| eng_word_i | input | $clog2(WORDS_PER_DESC) | Word index within the descriptor |
| eng_wdata_i | input | WORD_W | Engine write data |
| eng_gnt_o | output | 1 | Engine access granted this cycle |
| eng_rvalid_o | output | 1 | Engine read data valid |
| eng_rdata_o | output | WORD_W | Engine read data |
| slv_req_i | input | 1 | Slave access request, held until ready |
| slv_we_i | input | 1 | Slave write (1) or read (0) |
| slv_addr_i | input | $clog2(CHAN_NUM*WORDS_PER_DESC)+1 | Slave address of a 32-bit unit, bit 0 selects the half |
| slv_wdata_i | input | WORD_W/2 | Slave write data |
| slv_ready_o | output | 1 | Slave access complete |
| slv_rvalid_o | output | 1 | Slave read data valid |
| slv_rdata_o | output | WORD_W/2 | Slave read data |

## Verification
Engine writes and reads run over the first, a middle and the last channel, in every word position. These patterns show whether the channel and word indices combine into the right address. Slave reads of both halves, and slave writes of one half followed by full-word engine reads, show whether the half select works and whether the merge keeps the untouched half. Two contention patterns are timed through the measured latency of each side. In the first, both sides request in the same cycle, which shows whether the engine keeps priority and the slave is stalled. In the second, the engine arrives during a slave write's merge cycle, which shows whether the write is atomic.

// File: rtl/desc_pkg.sv
package desc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // RAM free for a new slave access
    ST_SRD  = 2'd1,  // slave read data on RAM output
    ST_SWR  = 2'd2   // slave merge-write cycle, engine locked out
  } arb_state_e;
endpackage

// File: rtl/desc_addr_gen.sv
module desc_addr_gen #(
  parameter int CHAN_NUM       = 16,
  parameter int WORDS_PER_DESC = 4,
  localparam int CHW = $clog2(CHAN_NUM),
  localparam int WIW = $clog2(WORDS_PER_DESC),
  localparam int AW  = $clog2(CHAN_NUM * WORDS_PER_DESC)
) (
  input  logic [CHW-1:0] chan_i,
  input  logic [WIW-1:0] word_i,
  output logic [AW-1:0]  addr_o
);
  generate
    if ((1 << WIW) == WORDS_PER_DESC) begin : g_pow2
      assign addr_o = AW'({chan_i, word_i});
    end else begin : g_mul
      assign addr_o = AW'(chan_i) * AW'(WORDS_PER_DESC) + AW'(word_i);
    end
  endgenerate
endmodule

// File: rtl/desc_sp_ram.sv
module desc_sp_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/desc_arb.sv
module desc_arb
  import desc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       eng_req_i,
  input  logic       slv_req_i,
  input  logic       slv_we_i,
  output logic       eng_gnt_o,
  output logic       slv_go_o,
  output arb_state_e state_o
);
  arb_state_e state_q, state_d;

  assign eng_gnt_o = eng_req_i && (state_q != ST_SWR);
  // slave starts only from idle and only when the engine is absent
  assign slv_go_o  = slv_req_i && !eng_req_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = ST_IDLE;
    if (slv_go_o) state_d = slv_we_i ? ST_SWR : ST_SRD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_eng_prio_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_i && slv_req_i && state_q == ST_IDLE) |=> (state_q == ST_IDLE));

  p_busy_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/desc_mem_ctrl.sv
module desc_mem_ctrl
  import desc_pkg::*;
#(
  parameter int CHAN_NUM       = 16,
  parameter int WORDS_PER_DESC = 4,
  parameter int WORD_W         = 64
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      eng_req_i,
  input  logic                                      eng_we_i,
  input  logic [$clog2(CHAN_NUM)-1:0]               eng_chan_i,
  input  logic [$clog2(WORDS_PER_DESC)-1:0]         eng_word_i,
  input  logic [WORD_W-1:0]                         eng_wdata_i,
  output logic                                      eng_gnt_o,
  output logic                                      eng_rvalid_o,
  output logic [WORD_W-1:0]                         eng_rdata_o,
  input  logic                                      slv_req_i,
  input  logic                                      slv_we_i,
  input  logic [$clog2(CHAN_NUM*WORDS_PER_DESC):0]  slv_addr_i,
  input  logic [WORD_W/2-1:0]                       slv_wdata_i,
  output logic                                      slv_ready_o,
  output logic                                      slv_rvalid_o,
  output logic [WORD_W/2-1:0]                       slv_rdata_o
);
  localparam int DEPTH  = CHAN_NUM * WORDS_PER_DESC;
  localparam int AW     = $clog2(DEPTH);
  localparam int HALF_W = WORD_W / 2;

  logic              slv_go, wr_phase;
  arb_state_e        state;
  logic [AW-1:0]     eng_addr, ram_addr;
  logic              ram_en, ram_we;
  logic [WORD_W-1:0] ram_wdata, ram_rdata, merged;
  logic              eng_rd_q;

  desc_addr_gen #(.CHAN_NUM(CHAN_NUM), .WORDS_PER_DESC(WORDS_PER_DESC)) u_addr (
    .chan_i (eng_chan_i),
    .word_i (eng_word_i),
    .addr_o (eng_addr)
  );

  desc_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eng_req_i (eng_req_i),
    .slv_req_i (slv_req_i),
    .slv_we_i  (slv_we_i),
    .eng_gnt_o (eng_gnt_o),
    .slv_go_o  (slv_go),
    .state_o   (state)
  );

  assign wr_phase = (state == ST_SWR);

  // slave half merged into the word read in the previous cycle
  assign merged = slv_addr_i[0] ? {slv_wdata_i, ram_rdata[HALF_W-1:0]}
                                : {ram_rdata[WORD_W-1:HALF_W], slv_wdata_i};

  assign ram_en    = eng_gnt_o || slv_go || wr_phase;
  assign ram_we    = eng_gnt_o ? eng_we_i : wr_phase;
  assign ram_addr  = eng_gnt_o ? eng_addr : slv_addr_i[AW:1];
  assign ram_wdata = eng_gnt_o ? eng_wdata_i : merged;

  desc_sp_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .clk_i   (clk_i),
    .en_i    (ram_en),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eng_rd_q <= 1'b0;
    else         eng_rd_q <= eng_gnt_o && !eng_we_i;
  end

  assign eng_rvalid_o = eng_rd_q;
  assign eng_rdata_o  = ram_rdata;
  assign slv_ready_o  = (state != ST_IDLE);
  assign slv_rvalid_o = (state == ST_SRD);
  assign slv_rdata_o  = slv_addr_i[0] ? ram_rdata[WORD_W-1:HALF_W] : ram_rdata[HALF_W-1:0];

  p_eng_rvalid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_gnt_o && !eng_we_i) |=> eng_rvalid_o);

  p_eng_wr_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_gnt_o && eng_we_i) |=> !eng_rvalid_o);

  p_slv_go_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_go |=> slv_ready_o);

  p_rvalid_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_rvalid_o |-> (slv_ready_o && !slv_we_i));

  p_wr_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_ready_o && !slv_rvalid_o) |-> !eng_gnt_o);

  p_ready_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_ready_o |=> !slv_ready_o);

  p_slv_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_req_i && !slv_ready_o) |=>
      (slv_req_i && $stable(slv_we_i) && $stable(slv_addr_i) && $stable(slv_wdata_i)));

  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!eng_rvalid_o && !slv_ready_o && !slv_rvalid_o));
endmodule

// File: tb/sim_desc_mem_ctrl.sv
module sim_desc_mem_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WPD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eng_req = 1'b0, eng_we = 1'b0;
  logic [3:0]  eng_chan = '0;
  logic [1:0]  eng_word = '0;
  logic [63:0] eng_wdata = '0;
  logic        eng_gnt, eng_rvalid;
  logic [63:0] eng_rdata;
  logic        slv_req = 1'b0, slv_we = 1'b0;
  logic [6:0]  slv_addr = '0;
  logic [31:0] slv_wdata = '0;
  logic        slv_ready, slv_rvalid;
  logic [31:0] slv_rdata;

  int checks = 0;
  int errors = 0;

  logic [63:0] model [64];
  logic [63:0] eng_q[$];
  string       eng_tag[$];
  logic [31:0] slv_q[$];
  string       slv_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_mem_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .eng_req_i(eng_req), .eng_we_i(eng_we), .eng_chan_i(eng_chan),
    .eng_word_i(eng_word), .eng_wdata_i(eng_wdata),
    .eng_gnt_o(eng_gnt), .eng_rvalid_o(eng_rvalid), .eng_rdata_o(eng_rdata),
    .slv_req_i(slv_req), .slv_we_i(slv_we), .slv_addr_i(slv_addr),
    .slv_wdata_i(slv_wdata), .slv_ready_o(slv_ready),
    .slv_rvalid_o(slv_rvalid), .slv_rdata_o(slv_rdata)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int c, input int w);
    return {32'hC0DE0000 ^ 32'(c * 16 + w), 32'h12340000 + 32'(c * WPD + w)};
  endfunction

  // engine driver; lat = negedges until grant
  task automatic eng_op(input bit we, input int c, input int w, input logic [63:0] d,
                        input string tag, output int lat);
    @(posedge clk); #1;
    eng_req = 1'b1; eng_we = we; eng_chan = 4'(c); eng_word = 2'(w); eng_wdata = d;
    if (we) model[c * WPD + w] = d;
    else begin
      eng_q.push_back(model[c * WPD + w]);
      eng_tag.push_back(tag);
    end
    lat = 0;
    forever begin
      @(negedge clk); lat++;
      if (eng_gnt) break;
    end
    @(posedge clk); #1;
    eng_req = 1'b0;
  endtask

  // slave driver; lat = negedges until ready
  task automatic slv_op(input bit we, input int word, input bit hi, input logic [31:0] d,
                        input string tag, output int lat);
    @(posedge clk); #1;
    slv_req = 1'b1; slv_we = we; slv_addr = {6'(word), hi}; slv_wdata = d;
    if (we) begin
      if (hi) model[word][63:32] = d;
      else    model[word][31:0]  = d;
    end else begin
      slv_q.push_back(hi ? model[word][63:32] : model[word][31:0]);
      slv_tag.push_back(tag);
    end
    lat = 0;
    forever begin
      @(negedge clk); lat++;
      if (slv_ready) break;
    end
    @(posedge clk); #1;
    slv_req = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && eng_rvalid) begin
      if (eng_q.size() == 0) chk("R3 unexpected engine rvalid", 64'd1, 64'd0);
      else chk(eng_tag.pop_front(), eng_rdata, eng_q.pop_front());
    end
    if (rst_n && slv_rvalid) begin
      if (slv_q.size() == 0) chk("R6 unexpected slave rvalid", 64'd1, 64'd0);
      else chk(slv_tag.pop_front(), 64'(slv_rdata), 64'(slv_q.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int la, lb;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 eng_rvalid in reset", 64'(eng_rvalid), 64'd0);
    chk("R9 slv_ready in reset", 64'(slv_ready), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 slv_rvalid after reset", 64'(slv_rvalid), 64'd0);
    chk("R9 slv_ready after reset", 64'(slv_ready), 64'd0);

    // R1 R3: engine writes over first, middle and last channels
    foreach (model[i]) model[i] = '0;
    for (int c = 0; c < 16; c++)
      for (int w = 0; w < WPD; w++) begin
        eng_op(1'b1, c, w, pat(c, w), "R3 write", la);
        if (c == 0 && w == 0) chk("R3 engine write grant latency", 64'(la), 64'd1);
      end
    for (int c = 0; c < 16; c += 5)
      for (int w = 0; w < WPD; w++) begin
        eng_op(1'b0, c, w, '0, "R1 engine readback", la);
        if (w == 1) chk("R3 engine read grant latency", 64'(la), 64'd1);
      end

    // R4 R5: slave reads of both halves
    slv_op(1'b0, 5 * WPD + 2, 1'b0, '0, "R4 slave low half", la);
    chk("R5 slave read latency", 64'(la), 64'd2);
    slv_op(1'b0, 5 * WPD + 2, 1'b1, '0, "R4 slave high half", la);
    slv_op(1'b0, 15 * WPD + 3, 1'b1, '0, "R4 slave last word high", la);

    // R6: half writes keep the other half
    slv_op(1'b1, 5 * WPD + 2, 1'b0, 32'hDEADBEEF, "R6", la);
    chk("R6 slave write latency", 64'(la), 64'd2);
    eng_op(1'b0, 5, 2, '0, "R6 low-half merge", la);
    slv_op(1'b1, 15 * WPD + 3, 1'b1, 32'hA5A55A5A, "R6", la);
    eng_op(1'b0, 15, 3, '0, "R6 high-half merge", la);
    slv_op(1'b0, 15 * WPD + 3, 1'b0, '0, "R6 untouched low half", la);

    // R2: simultaneous requests
    fork
      eng_op(1'b0, 0, 1, '0, "R2 engine read under contention", la);
      slv_op(1'b0, 10 * WPD + 0, 1'b1, '0, "R2 stalled slave read", lb);
    join
    chk("R2 engine latency under contention", 64'(la), 64'd1);
    chk("R2 slave stalled latency", 64'(lb), 64'd3);
    fork
      eng_op(1'b1, 1, 0, 64'h0123456789ABCDEF, "R2", la);
      slv_op(1'b1, 2 * WPD + 0, 1'b0, 32'h0BADF00D, "R2", lb);
    join
    chk("R2 slave write stalled latency", 64'(lb), 64'd3);
    eng_op(1'b0, 1, 0, '0, "R2 engine write landed", la);
    eng_op(1'b0, 2, 0, '0, "R2 slave write landed", la);

    // R7: engine waits through merge cycle
    fork
      slv_op(1'b1, 3 * WPD + 1, 1'b1, 32'hFACE0FF0, "R7", lb);
      begin @(posedge clk); eng_op(1'b0, 10, 3, '0, "R7 delayed engine read", la); end
    join
    chk("R7 engine delayed by merge cycle", 64'(la), 64'd2);
    chk("R7 slave write latency", 64'(lb), 64'd2);
    eng_op(1'b0, 3, 1, '0, "R7 atomic write result", la);

    repeat (4) @(negedge clk);
    chk("R3 engine scoreboard drained", 64'(eng_q.size()), 64'd0);
    chk("R5 slave scoreboard drained", 64'(slv_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule